// File: doc/BRIEF.md
# Pin Interrupt Detection Unit

This block watches 64 general-purpose input pins and turns selected pin activity into a single interrupt request. Each pin is first brought into the core clock domain through a two-stage synchronizer. Software then chooses, one bit per pin, whether that pin is sensed by level or by edge, which level or edge direction counts, and whether an edge-sensed pin reacts to transitions in either direction.

Edge events are latched in a raw status vector until software clears them by writing ones. Level-sensed pins show their qualified level in the same vector live, with no latching. A per-pin enable vector masks the raw status into a masked status vector. A single global enable bit gates the registered interrupt output and stops new edge events from latching. All per-pin vectors sit at an even word offset for pins 0 to 31 and at that offset plus 4 for pins 32 to 63. They are reached over a plain 32-bit word read/write port whose read data is registered.

Top module: `pinirq_top`

## Requirements
- R1: Every per-pin vector is split over two words: pins 0..31 at the base offset and pins 32..63 at base+4. A read request returns its data on `rd_data` one clock edge later. Unmapped addresses read 0.
- R2: The sense-type vector (0x10/0x14) selects edge sensing with a 1 and level sensing with a 0.
- R3: The polarity vector (0x20/0x24) selects rising edge or high level with a 1, and falling edge or low level with a 0.
- R4: For an edge-sensed pin whose bit in the dual-edge vector (0x18/0x1C) is 1, both transitions latch status and its polarity bit is ignored.
- R5: For a level-sensed pin, the raw status bit follows the synchronized pin level compared with polarity, and it drops again without any clear.
- R6: Latched edge status stays set until a 1 is written to that pin's bit in the clear words (0x30/0x34). Zero bits in a clear write change nothing.
- R7: When a new edge and a clear for the same pin occur in the same cycle, the status bit ends up set.
- R8: The enable vector (0x28/0x2C) resets to all zeros. Masked status (0x40/0x44) equals raw status (0x38/0x3C) ANDed with the enable vector.
- R9: The global enable is bit 0 at 0x00 and resets to 0. `irq` is the registered OR of all masked status bits ANDed with the global enable.
- R10: While the global enable is 0, no edge event latches.
- R11: The input-level words (0x48/0x4C) return the pin levels after the two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of a 32-bit word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pins | input | 64 | Asynchronous pin levels |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is a clear write that lands on exactly the clock edge where a new edge reaches the status register. This happens two synchronizer stages plus one compare stage after the pin moves. The bench counts those edges from the negative edge on which it drives the pin, then issues the clear write so that it commits on that same edge. It then reads the bit back.

Random configurations of sense type, dual-edge, polarity and enable are also driven across pin transitions with a fixed seed. The resulting raw status, masked status and `irq` are compared against values computed by bench functions.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int unsigned ADDR_W = 8;
  // word offsets; the +4 word of each pair carries pins 32..63
  localparam logic [ADDR_W-1:0] OFS_GEN  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TYPE = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_BOTH = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_POL  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_IE   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_MSK  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 8'h48;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect #(
  parameter int unsigned NPIN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gen_en,
  input  logic [NPIN-1:0] pin_s,
  input  logic [NPIN-1:0] is_edge,
  input  logic [NPIN-1:0] dual,
  input  logic [NPIN-1:0] pol,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] raw_q
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] lvl;
  logic [NPIN-1:0] hold_v;

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      always_comb begin
        lvl[i] = ~(pin_s[i] ^ pol[i]);
        if (dual[i]) hit[i] = pin_s[i] ^ prev_q[i];
        else if (pol[i]) hit[i] = pin_s[i] & ~prev_q[i];
        else hit[i] = ~pin_s[i] & prev_q[i];
      end

      always_ff @(posedge clk) begin
        if (rst) raw_q[i] <= 1'b0;
        else if (!is_edge[i]) raw_q[i] <= lvl[i];
        else raw_q[i] <= (raw_q[i] & ~clr[i]) | (hit[i] & gen_en);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else prev_q <= pin_s;
  end

  assign hold_v = raw_q & is_edge & ~clr;

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(hold_v)) == $past(hold_v))); // R6

  AST_GEN_BLOCKS_EDGE: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> ((raw_q & ~$past(raw_q) & $past(is_edge)) == '0)); // R10
endmodule

// File: rtl/pinirq_top.sv
module pinirq_top
  import pinirq_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [2*DATA_W-1:0] pins,
  output logic              irq
);
  localparam int unsigned NPIN  = 2 * DATA_W;
  localparam int unsigned NHALF = 2;

  logic              gen_q;
  logic [NPIN-1:0]   type_q, dual_q, pol_q, ie_q;
  logic [NPIN-1:0]   pin_s, raw, masked, clr;
  logic [ADDR_W-1:0] base;
  logic              upper;
  logic [DATA_W-1:0] rd_mux;
  logic              irq_q;
  logic [DATA_W-1:0] rd_q;

  assign base  = {addr[ADDR_W-1:3], 3'b000};
  assign upper = addr[2] & (addr[1:0] == 2'b00);

  pinirq_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins), .q(pin_s)
  );

  pinirq_detect #(.NPIN(NPIN)) u_detect (
    .clk(clk), .rst(rst), .gen_en(gen_q), .pin_s(pin_s),
    .is_edge(type_q), .dual(dual_q), .pol(pol_q), .clr(clr), .raw_q(raw)
  );

  assign masked = raw & ie_q;

  always_comb begin
    clr = '0;
    if (wr_en && base == OFS_CLR && addr[1:0] == 2'b00) begin
      for (int h = 0; h < NHALF; h++)
        if (upper == 1'(h)) clr[h*DATA_W +: DATA_W] = wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q  <= 1'b0;
      type_q <= '0;
      dual_q <= '0;
      pol_q  <= '0;
      ie_q   <= '0;
    end else if (wr_en && addr[1:0] == 2'b00) begin
      if (addr == OFS_GEN) gen_q <= wr_data[0];
      for (int h = 0; h < NHALF; h++) begin
        if (upper == 1'(h)) begin
          case (base)
            OFS_TYPE: type_q[h*DATA_W +: DATA_W] <= wr_data;
            OFS_BOTH: dual_q[h*DATA_W +: DATA_W] <= wr_data;
            OFS_POL:  pol_q[h*DATA_W +: DATA_W]  <= wr_data;
            OFS_IE:   ie_q[h*DATA_W +: DATA_W]   <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [DATA_W-1:0] pick(input logic [NPIN-1:0] v, input logic hi);
    return hi ? v[NPIN-1:DATA_W] : v[DATA_W-1:0];
  endfunction

  always_comb begin
    rd_mux = '0;
    if (addr[1:0] == 2'b00) begin
      case (base)
        OFS_GEN:  rd_mux = upper ? '0 : {{(DATA_W-1){1'b0}}, gen_q};
        OFS_TYPE: rd_mux = pick(type_q, upper);
        OFS_BOTH: rd_mux = pick(dual_q, upper);
        OFS_POL:  rd_mux = pick(pol_q, upper);
        OFS_IE:   rd_mux = pick(ie_q, upper);
        OFS_RAW:  rd_mux = pick(raw, upper);
        OFS_MSK:  rd_mux = pick(masked, upper);
        OFS_DIN:  rd_mux = pick(pin_s, upper);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      rd_q  <= rd_en ? rd_mux : '0;
      irq_q <= gen_q & (|masked);
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

  AST_IRQ_NEEDS_GEN: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(gen_q)); // R9

  AST_IE_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (ie_q == '0 && !irq_q)); // R8

  AST_IRQ_FROM_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past((raw & ie_q) != '0)); // R9
endmodule

// File: tb/tb_pinirq_top.sv
module tb_pinirq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [63:0] pins = '0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinirq_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .pins(pins), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wr64(input logic [7:0] a, input logic [63:0] d);
    wr(a, d[31:0]);
    wr(a + 8'd4, d[63:32]);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd64(input logic [7:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 8'd4, hi);
    d = {hi, lo};
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_raw(input logic [63:0] typ, input logic [63:0] dual,
                                          input logic [63:0] pol, input logic [63:0] a,
                                          input logic [63:0] b);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      if (!typ[i]) r[i] = (b[i] == pol[i]);
      else if (dual[i]) r[i] = a[i] ^ b[i];
      else if (pol[i]) r[i] = !a[i] && b[i];
      else r[i] = a[i] && !b[i];
    end
    return r;
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [63:0] v, typ, dual, pol, ie, a, b, er;
    logic [31:0] w;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd64(8'h28, v); chk("R8 enable reset", v, 64'h0);
    rd(8'h00, w);   chk("R9 global enable reset", {32'h0, w}, 64'h0);
    chk("R9 irq after reset", {63'h0, irq}, 64'h0);
    rd(8'h44, w);   chk("R1 unmapped/masked high reads zero", {32'h0, w}, 64'h0);

    // synchronized levels
    pins = 64'hA5C3_0F1E_9966_7788;
    settle();
    rd64(8'h48, v); chk("R11 input levels", v, 64'hA5C3_0F1E_9966_7788);
    rd(8'h4C, w);   chk("R1 high word holds pins 32..63", {32'h0, w}, 64'hA5C3_0F1E);

    // edges blocked with global enable low
    wr64(8'h10, '1);
    wr64(8'h20, '1);
    wr64(8'h28, '1);
    wr64(8'h30, '1);
    pins = ~pins;
    settle();
    rd64(8'h38, v); chk("R10 no latch with global enable 0", v, 64'h0);
    chk("R10 irq low with global enable 0", {63'h0, irq}, 64'h0);

    // rising edge on pin 3
    pins = '0;
    settle();
    wr(8'h00, 32'h1);
    wr64(8'h30, '1);
    pins[3] = 1'b1;
    settle();
    rd64(8'h38, v); chk("R2 R3 rising edge latched", v, 64'h8);
    rd64(8'h40, v); chk("R8 masked status", v, 64'h8);
    chk("R9 irq raised", {63'h0, irq}, 64'h1);

    // clear behaviour
    wr(8'h30, 32'h0);
    rd64(8'h38, v); chk("R6 zero clear has no effect", v, 64'h8);
    wr(8'h30, 32'h20);
    rd64(8'h38, v); chk("R6 other-bit clear has no effect", v, 64'h8);
    wr(8'h30, 32'h8);
    rd64(8'h38, v); chk("R6 clear by writing one", v, 64'h0);
    @(negedge clk);
    chk("R9 irq dropped after clear", {63'h0, irq}, 64'h0);

    // dual edge: falling edge latches with polarity 1
    wr(8'h18, 32'h8);
    pins[3] = 1'b0;
    settle();
    rd64(8'h38, v); chk("R4 dual edge ignores polarity", v, 64'h8);

    // edge arrives on the same edge as the clear write
    @(negedge clk);
    pins[3] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    wr(8'h30, 32'h8);
    rd64(8'h38, v); chk("R7 new edge beats clear", v, 64'h8);
    wr(8'h30, 32'h8);
    rd64(8'h38, v); chk("R7 later clear works", v, 64'h0);

    // level mode on pin 0, high active
    wr(8'h18, 32'h0);
    wr(8'h10, 32'hFFFF_FFFE);
    pins[0] = 1'b1;
    settle();
    rd(8'h38, w); chk("R5 level high shown", {63'h0, w[0]}, 64'h1);
    pins[0] = 1'b0;
    settle();
    rd(8'h38, w); chk("R5 level drops without clear", {63'h0, w[0]}, 64'h0);

    // random configurations
    for (int it = 0; it < 16; it++) begin
      typ  = {$urandom, $urandom};
      dual = {$urandom, $urandom};
      pol  = {$urandom, $urandom};
      ie   = {$urandom, $urandom};
      a    = {$urandom, $urandom};
      b    = (it % 4 == 0) ? ~a : {$urandom, $urandom};
      pins = a;
      wr64(8'h10, typ);
      wr64(8'h18, dual);
      wr64(8'h20, pol);
      wr64(8'h28, ie);
      settle();
      wr64(8'h30, '1);
      pins = b;
      settle();
      er = exp_raw(typ, dual, pol, a, b);
      rd64(8'h38, v); chk("R2 R3 R4 R5 random raw", v, er);
      rd64(8'h40, v); chk("R8 random masked", v, er & ie);
      rd64(8'h28, v); chk("R8 enable readback", v, ie);
      @(negedge clk);
      chk("R9 random irq", {63'h0, irq}, {63'h0, |(er & ie)});
    end

    finish_run();
  end
endmodule